// File: doc/BRIEF.md
# Register-Mapped Pin Controller with Latched Pull Control

This block drives a bank of 54 general-purpose pads from a 32-bit word-addressed register port. For each pin it holds a 3-bit function code, an output latch and a captured pull setting. The function code goes to the pad ring unchanged, and the pad output driver is enabled only when the code selects plain output. The output latch is never written directly. Software raises pins through set registers and lowers them through clear registers, and a level register returns the live state of every pin.

Pull resistors are not programmed directly. Software loads a pull mode that all pins share and then raises the pull-strobe bits of the pins that should take it. A small sequencer with three states (SEQ_IDLE, SEQ_APPLY, SEQ_HOLD) records which strobe bits rose, and one cycle later it copies the mode into those pins only. SEQ_IDLE moves to SEQ_APPLY when any strobe bit rises. SEQ_APPLY stays in SEQ_APPLY if another bit rises in the same cycle. Otherwise it moves to SEQ_HOLD while any strobe bit is still high, or back to SEQ_IDLE when none is. SEQ_HOLD follows the same rules as SEQ_APPLY. Because only rising strobe bits capture, software can clear the mode and the strobes in either order without disturbing any pin.

Top module: `pinctl_top`

## Requirements
- R1: After reset every pin has function code 0, output enable low, output latch 0 and pull code 0. The pull mode, pull strobe and function-select words read 0, and the read data port is 0.
- R2: Pin p's function code sits in word p/10 (word addresses 0 to 5) at bits (p mod 10)*3 upward. A write replaces every field in that word, a read returns them, and the code appears on pad_func bits p*3 upward from the next cycle.
- R3: Output enable of a pin is high exactly when its function code is 1. Code 0 and codes 2 to 7 leave it low while pad_func still carries the code.
- R4: Set words 7 and 8 map pin p to word 7+p/32, bit p mod 32. A 1 bit drives that pin's output latch high from the cycle after the write, and 0 bits leave latches unchanged.
- R5: Clear words 10 and 11 use the same mapping and drive the latch low. Set and clear words read as 0.
- R6: The output latch keeps its value when the pin's function code changes.
- R7: Level words 13 and 14 use the same mapping. A pin with output enable high returns its output latch. Any other pin returns pad_in through two flops, so a read sampled on the first or second edge after a pad change returns the old level and a read on the third edge returns the new one.
- R8: Pull mode word 37 holds 2 bits (0 none, 1 pull-down, 2 pull-up) and reads back as written. Code 3 is captured into pins as 0.
- R9: Pull strobe words 38 and 39 map pin p to word 38+p/32, bit p mod 32, and read back as written. When a strobe bit goes from 0 to 1, the mode held at that write is copied into that pin's pad_pull field (bits p*2 upward), visible after the second rising edge that follows the write. Pins whose bit did not rise keep their setting.
- R10: Clearing the mode and the strobes in either order, or changing the mode while a strobe bit stays high, leaves every captured pull code unchanged.
- R11: Word addresses outside the map read 0. Bits 30 and 31 of function words, fields beyond pin 53 (word 5 bits 12 and up) and level and strobe bits for pins 54 to 63 read 0.
- R12: bus_rdata is loaded at every rising edge where bus_re is high, with the word addressed in that cycle. It holds its value while bus_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 54 | Pad input levels, asynchronous |
| pad_out | output | 54 | Output latch per pin |
| pad_oe | output | 54 | Output driver enable per pin |
| pad_func | output | 162 | 3-bit function code per pin |
| pad_pull | output | 108 | 2-bit captured pull code per pin |

## Verification
A stuck or mis-advanced sequencer state shows on pad_pull. A field moves two edges after a strobe write that did not raise its bit, or fails to move when the bit did rise, and an apply cycle left behind repeats the capture after the mode changes. A corrupted output latch appears on pad_out one edge after a set or clear write and on the next level read of an output pin. A synchronizer fault shifts by one cycle the read at which a new pad level first appears. Field-mapping errors show on the first read of a function, level or strobe word, since the expected value of every bit is known.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned FN_W   = 3;
    localparam int unsigned PULL_W = 2;

    // word addresses (byte offset / 4)
    localparam int unsigned FSEL_WORD  = 0;
    localparam int unsigned SET_WORD   = 7;
    localparam int unsigned CLR_WORD   = 10;
    localparam int unsigned LEVEL_WORD = 13;
    localparam int unsigned PMODE_WORD = 37;
    localparam int unsigned PCLK_WORD  = 38;

    localparam logic [FN_W-1:0] FN_INPUT  = 3'd0;
    localparam logic [FN_W-1:0] FN_OUTPUT = 3'd1;

    typedef enum logic [PULL_W-1:0] {
        PULL_NONE = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_UP   = 2'd2
    } pull_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_APPLY = 2'd1,
        SEQ_HOLD  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/pinctl_fsel.sv
module pinctl_fsel
    import pinctl_pkg::*;
#(
    parameter int unsigned NUM_PINS = 54,
    parameter int unsigned PER_WORD = 10,
    parameter int unsigned ADDR_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [WORD_W-1:0]        wdata,
    output logic [NUM_PINS*FN_W-1:0] func,
    output logic [WORD_W-1:0]        rd_word
);

    localparam int unsigned USED_BITS = PER_WORD * FN_W;

    logic [NUM_PINS*FN_W-1:0] fn_q;
    logic                     unused_fsel_bits;

    assign unused_fsel_bits = ^wdata[WORD_W-1:USED_BITS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fn_q <= '0;
        end else if (wr_en) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (addr == ADDR_W'(FSEL_WORD + p / PER_WORD)) begin
                    fn_q[p*FN_W +: FN_W] <= wdata[(p % PER_WORD)*FN_W +: FN_W];
                end
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (addr == ADDR_W'(FSEL_WORD + p / PER_WORD)) begin
                rd_word[(p % PER_WORD)*FN_W +: FN_W] = fn_q[p*FN_W +: FN_W];
            end
        end
    end

    assign func = fn_q;

endmodule

// File: rtl/pinctl_outreg.sv
module pinctl_outreg
    import pinctl_pkg::*;
#(
    parameter int unsigned NUM_PINS = 54,
    parameter int unsigned ADDR_W   = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [WORD_W-1:0]                   wdata,
    input  logic [NUM_PINS-1:0]                 drive_en,
    input  logic [NUM_PINS-1:0]                 pad_in,
    output logic [NUM_PINS-1:0]                 out_val,
    output logic [((NUM_PINS+WORD_W-1)/WORD_W)*WORD_W-1:0] level
);

    logic [NUM_PINS-1:0] out_q;
    logic [NUM_PINS-1:0] set_m;
    logic [NUM_PINS-1:0] clr_m;
    logic [NUM_PINS-1:0] sync1_q;
    logic [NUM_PINS-1:0] sync2_q;

    always_comb begin
        set_m = '0;
        clr_m = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (wr_en && addr == ADDR_W'(SET_WORD + p / WORD_W)) begin
                set_m[p] = wdata[p % WORD_W];
            end
            if (wr_en && addr == ADDR_W'(CLR_WORD + p / WORD_W)) begin
                clr_m[p] = wdata[p % WORD_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            out_q   <= (out_q | set_m) & ~clr_m;
            sync1_q <= pad_in;
            sync2_q <= sync1_q;
        end
    end

    always_comb begin
        level = '0;
        level[NUM_PINS-1:0] = (drive_en & out_q) | (~drive_en & sync2_q);
    end

    assign out_val = out_q;

endmodule

// File: rtl/pinctl_pullseq.sv
module pinctl_pullseq
    import pinctl_pkg::*;
#(
    parameter int unsigned NUM_PINS = 54,
    parameter int unsigned ADDR_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [WORD_W-1:0]          wdata,
    output logic [NUM_PINS*PULL_W-1:0] pull,
    output logic [PULL_W-1:0]          mode_rd,
    output logic [((NUM_PINS+WORD_W-1)/WORD_W)*WORD_W-1:0] strobe_rd
);

    seq_state_e                state_q;
    seq_state_e                state_d;
    logic [PULL_W-1:0]         mode_q;
    logic [PULL_W-1:0]         capture_code;
    logic [NUM_PINS-1:0]       strobe_q;
    logic [NUM_PINS-1:0]       strobe_d;
    logic [NUM_PINS-1:0]       rise_d;
    logic [NUM_PINS-1:0]       pend_q;
    logic [NUM_PINS*PULL_W-1:0] pull_q;

    // next strobe image and the bits that rise with this write
    always_comb begin
        strobe_d = strobe_q;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (wr_en && addr == ADDR_W'(PCLK_WORD + p / WORD_W)) begin
                strobe_d[p] = wdata[p % WORD_W];
            end
        end
        rise_d = strobe_d & ~strobe_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= PULL_NONE;
            strobe_q <= '0;
            pend_q   <= '0;
        end else begin
            if (wr_en && addr == ADDR_W'(PMODE_WORD)) begin
                mode_q <= wdata[PULL_W-1:0];
            end
            strobe_q <= strobe_d;
            pend_q   <= rise_d;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (|rise_d) state_d = SEQ_APPLY;
            end
            SEQ_APPLY, SEQ_HOLD: begin
                if (|rise_d)        state_d = SEQ_APPLY;
                else if (|strobe_d) state_d = SEQ_HOLD;
                else                state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // the reserved mode code is captured as no pull
    always_comb begin
        capture_code = PULL_NONE;
        if (mode_q == PULL_DOWN || mode_q == PULL_UP) capture_code = mode_q;
    end

    // outputs: captured pull codes, written only in the apply state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_q <= '0;
        end else if (state_q == SEQ_APPLY) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (pend_q[p]) pull_q[p*PULL_W +: PULL_W] <= capture_code;
            end
        end
    end

    always_comb begin
        strobe_rd = '0;
        strobe_rd[NUM_PINS-1:0] = strobe_q;
    end

    assign pull    = pull_q;
    assign mode_rd = mode_q;

endmodule

// File: rtl/pinctl_top.sv
module pinctl_top
    import pinctl_pkg::*;
#(
    parameter int unsigned NUM_PINS = 54,
    parameter int unsigned PER_WORD = 10,
    parameter int unsigned ADDR_W   = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [WORD_W-1:0]            bus_wdata,
    input  logic                         bus_we,
    input  logic                         bus_re,
    output logic [WORD_W-1:0]            bus_rdata,
    input  logic [NUM_PINS-1:0]          pad_in,
    output logic [NUM_PINS-1:0]          pad_out,
    output logic [NUM_PINS-1:0]          pad_oe,
    output logic [NUM_PINS*FN_W-1:0]    pad_func,
    output logic [NUM_PINS*PULL_W-1:0]  pad_pull
);

    localparam int unsigned NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;

    logic [WORD_W-1:0]           fsel_rd;
    logic [NUM_BANKS*WORD_W-1:0] level_bits;
    logic [NUM_BANKS*WORD_W-1:0] strobe_bits;
    logic [PULL_W-1:0]           mode_bits;
    logic [WORD_W-1:0]           rd_d;
    logic [WORD_W-1:0]           rdata_q;

    pinctl_fsel #(
        .NUM_PINS (NUM_PINS),
        .PER_WORD (PER_WORD),
        .ADDR_W   (ADDR_W)
    ) u_fsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .func    (pad_func),
        .rd_word (fsel_rd)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
        assign pad_oe[p] = (pad_func[p*FN_W +: FN_W] == FN_OUTPUT);
    end

    pinctl_outreg #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W)
    ) u_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .drive_en (pad_oe),
        .pad_in   (pad_in),
        .out_val  (pad_out),
        .level    (level_bits)
    );

    pinctl_pullseq #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W)
    ) u_pullseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .pull      (pad_pull),
        .mode_rd   (mode_bits),
        .strobe_rd (strobe_bits)
    );

    // read mux; function words already return zero outside their range
    always_comb begin
        rd_d = fsel_rd;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(LEVEL_WORD + b)) rd_d = level_bits[b*WORD_W +: WORD_W];
            if (bus_addr == ADDR_W'(PCLK_WORD + b))  rd_d = strobe_bits[b*WORD_W +: WORD_W];
        end
        if (bus_addr == ADDR_W'(PMODE_WORD)) rd_d = {{(WORD_W-PULL_W){1'b0}}, mode_bits};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_re) rdata_q <= rd_d;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/pinctl_checker.sv
module pinctl_checker
    import pinctl_pkg::*;
#(
    parameter int unsigned NUM_PINS = 54,
    parameter int unsigned ADDR_W   = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        we,
    input logic                        re,
    input logic [ADDR_W-1:0]           addr,
    input logic [FN_W-1:0]             wd_lo,
    input logic [WORD_W-1:0]           rdata,
    input logic                        out0,
    input logic                        out32,
    input logic [FN_W-1:0]             fn0,
    input logic [NUM_PINS*PULL_W-1:0] pull
);

    localparam int unsigned NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;

    logic strobe_wr;
    assign strobe_wr = we && (addr >= ADDR_W'(PCLK_WORD)) &&
                       (addr < ADDR_W'(PCLK_WORD + NUM_BANKS));

    // R2: a function word write lands on the pad function of pin 0
    a_r2_fsel_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(FSEL_WORD)) |=> (fn0 == $past(wd_lo)));

    // R4: set bit drives the latch high in both banks
    a_r4_set_bank0: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(SET_WORD) && wd_lo[0]) |=> out0);

    a_r4_set_bank1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(SET_WORD + 1) && wd_lo[0]) |=> out32);

    // R5: clear bit drives the latch low
    a_r5_clear_bank0: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(CLR_WORD) && wd_lo[0]) |=> !out0);

    // R10: pull codes move only two edges after a strobe write
    a_r10_pull_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(strobe_wr, 2) |-> $stable(pull));

    // R12: read data holds without a read strobe
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));

    // R8: the reserved code never reaches a pad
    always @(posedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                a_r8_no_reserved_code: assert (pull[p*PULL_W +: PULL_W] != 2'b11);
            end
        end
    end

endmodule

bind pinctl_top pinctl_checker #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .re    (bus_re),
    .addr  (bus_addr),
    .wd_lo (bus_wdata[2:0]),
    .rdata (bus_rdata),
    .out0  (pad_out[0]),
    .out32 (pad_out[32]),
    .fn0   (pad_func[2:0]),
    .pull  (pad_pull)
);

// File: tb/test_pinctl_top.sv
module test_pinctl_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [5:0]   addr;
    logic [31:0]  wdata;
    logic         we;
    logic         re;
    logic [31:0]  rdata;
    logic [53:0]  pad_in;
    logic [53:0]  pad_out;
    logic [53:0]  pad_oe;
    logic [161:0] pad_func;
    logic [107:0] pad_pull;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    pinctl_top i_pinctl_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_we    (we),
        .bus_re    (re),
        .bus_rdata (rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_func  (pad_func),
        .pad_pull  (pad_pull)
    );

    // {op (0 write, 1 read), requirement, word address, data or expected}
    localparam int NV = 31;
    localparam logic [47:0] VEC [NV] = '{
        {4'd0, 4'd11, 8'd0,  32'hFFFF_FFFF},
        {4'd1, 4'd11, 8'd0,  32'h3FFF_FFFF},  // R11 top two bits
        {4'd0, 4'd11, 8'd5,  32'hFFFF_FFFF},
        {4'd1, 4'd11, 8'd5,  32'h0000_0FFF},  // R11 fields past pin 53
        {4'd0, 4'd2,  8'd0,  32'h0000_0249},
        {4'd1, 4'd2,  8'd0,  32'h0000_0249},  // R2
        {4'd0, 4'd4,  8'd7,  32'h0000_0005},
        {4'd1, 4'd4,  8'd13, 32'h0000_0005},  // R4 and R7 output pins
        {4'd0, 4'd5,  8'd10, 32'h0000_0001},
        {4'd1, 4'd5,  8'd13, 32'h0000_0004},  // R5
        {4'd0, 4'd4,  8'd10, 32'h0000_0000},
        {4'd1, 4'd4,  8'd13, 32'h0000_0004},  // R4 zero bits
        {4'd1, 4'd5,  8'd7,  32'h0000_0000},  // R5 set word reads 0
        {4'd0, 4'd4,  8'd8,  32'hFFFF_FFFF},
        {4'd1, 4'd7,  8'd14, 32'h0000_0000},  // R7 inputs show pad
        {4'd0, 4'd3,  8'd3,  32'h0924_9249},
        {4'd1, 4'd3,  8'd14, 32'h0000_00FF},  // R3
        {4'd0, 4'd3,  8'd5,  32'h0000_0249},
        {4'd1, 4'd11, 8'd14, 32'h003C_00FF},  // R11 pins 54-63
        {4'd1, 4'd7,  8'd13, 32'h0000_0004},  // R7
        {4'd1, 4'd11, 8'd63, 32'h0000_0000},  // R11 unmapped
        {4'd1, 4'd11, 8'd6,  32'h0000_0000},  // R11 gap word
        {4'd0, 4'd8,  8'd37, 32'h0000_0002},
        {4'd1, 4'd8,  8'd37, 32'h0000_0002},  // R8
        {4'd0, 4'd9,  8'd38, 32'h0000_0002},
        {4'd0, 4'd9,  8'd37, 32'h0000_0000},
        {4'd0, 4'd9,  8'd38, 32'h0000_0000},
        {4'd1, 4'd9,  8'd38, 32'h0000_0000},  // R9
        {4'd0, 4'd11, 8'd39, 32'hFFFF_FFFF},
        {4'd1, 4'd11, 8'd39, 32'h003F_FFFF},  // R11 strobe bits
        {4'd0, 4'd9,  8'd39, 32'h0000_0000}
    };

    logic [3:0]  v_op;
    logic [3:0]  v_req;
    logic [31:0] v_val;
    logic [31:0] rd;

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // tasks start and end at a falling edge
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        addr = a; re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; addr = '0; wdata = '0; we = 1'b0; re = 1'b0; pad_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state at the pads
        check("R1 pad_out", pad_out, 0);
        check("R1 pad_oe", pad_oe, 0);
        check("R1 pad_func", pad_func, 0);
        check("R1 pad_pull", pad_pull, 0);
        check("R1 rdata", rdata, 0);
        rst_n = 1'b1;
        bus_read(6'd37, rd); check("R1 pull mode", rd, 0);
        bus_read(6'd38, rd); check("R1 pull strobe", rd, 0);
        bus_read(6'd0, rd);  check("R1 function word", rd, 0);

        for (int i = 0; i < NV; i++) begin
            v_op  = VEC[i][47:44];
            v_req = VEC[i][43:40];
            v_val = VEC[i][31:0];
            if (v_op == 4'd0) begin
                bus_write(VEC[i][37:32], v_val);
            end else begin
                bus_read(VEC[i][37:32], rd);
                check($sformatf("R%0d vector %0d", v_req, i), rd, v_val);
            end
        end
        // R9: pin 1 took pull-up in the table, pins 32-53 took none
        check("R9 table pull state", pad_pull, 108'h8);

        // R9 capture timing on pin 5
        bus_write(6'd37, 32'd1);
        bus_write(6'd38, 32'h20);
        check("R9 pin5 before apply", pad_pull[11:10], 2'd0);
        settle();
        check("R9 pin5 after apply", pad_pull[11:10], 2'd1);
        // R10 strobe cleared before mode
        bus_write(6'd38, 32'h0);
        bus_write(6'd37, 32'h0);
        settle();
        check("R10 pin5 kept", pad_pull[11:10], 2'd1);
        // R10 mode change while strobe held
        bus_write(6'd37, 32'd2);
        bus_write(6'd38, 32'h40);
        settle();
        bus_write(6'd37, 32'd1);
        settle();
        settle();
        check("R10 pin6 held strobe", pad_pull[13:12], 2'd2);
        // R9 only the rising bit captures
        bus_write(6'd38, 32'hC0);
        settle();
        check("R9 pin7 captured", pad_pull[15:14], 2'd1);
        check("R9 pin6 untouched", pad_pull[13:12], 2'd2);
        bus_write(6'd38, 32'h0);
        bus_write(6'd37, 32'h0);
        settle();
        check("R10 all pulls after release", pad_pull, 108'h6408);

        // R8 reserved mode code captures as none
        bus_write(6'd37, 32'd2);
        bus_write(6'd39, 32'h1);
        settle();
        check("R8 pin32 pull-up", pad_pull[65:64], 2'd2);
        bus_write(6'd39, 32'h0);
        bus_write(6'd37, 32'd3);
        bus_read(6'd37, rd);
        check("R8 mode reads 3", rd, 32'd3);
        bus_write(6'd39, 32'h1);
        settle();
        check("R8 code 3 gives none", pad_pull[65:64], 2'd0);
        bus_write(6'd39, 32'h0);
        bus_write(6'd37, 32'h0);

        // R3 alternate code does not enable the driver
        bus_write(6'd0, 32'h0000_024A);
        check("R3 pin0 oe", pad_oe[0], 1'b0);
        check("R3 pin0 code", pad_func[2:0], 3'd2);
        check("R3 pin1 oe", pad_oe[1], 1'b1);

        // R6 latch survives function changes
        bus_write(6'd0, 32'h0);
        check("R6 pin2 latch", pad_out[2], 1'b1);
        check("R6 pin2 oe", pad_oe[2], 1'b0);
        bus_write(6'd0, 32'h0000_0249);
        bus_read(6'd13, rd);
        check("R6 level after re-enable", rd, 32'h4);

        // R7 two-flop latency; pin0 drives so its pad is ignored
        pad_in[5] = 1'b1;
        pad_in[0] = 1'b1;
        bus_read(6'd13, rd); check("R7 first edge", rd, 32'h4);
        bus_read(6'd13, rd); check("R7 second edge", rd, 32'h4);
        bus_read(6'd13, rd); check("R7 third edge", rd, 32'h24);

        // R12 read data held across a write
        bus_write(6'd7, 32'h1);
        check("R12 rdata held", rdata, 32'h24);
        check("R4 pin0 set", pad_out[0], 1'b1);

        // R1 reset in mid-run
        rst_n = 1'b0;
        settle();
        check("R1 mid pad_out", pad_out, 0);
        check("R1 mid pad_func", pad_func, 0);
        check("R1 mid pad_pull", pad_pull, 0);
        check("R1 mid rdata", rdata, 0);
        rst_n = 1'b1;
        bus_read(6'd0, rd);  check("R1 mid function word", rd, 0);
        bus_read(6'd39, rd); check("R1 mid strobe word", rd, 0);

        done = 1'b1;
        finish_run();
    end

endmodule